// File: doc/BRIEF.md
# Serial Status Interrupt Edge Detector

This block sits beside a serial controller and its DMA engines. It turns their level status bits into sticky interrupt flags, one flag per event. Some events fire when their status bit rises and others when it falls. Two further events come from single-cycle pulses: a lost receive byte and a transmit underrun. Software reads the flag vector, clears flags by writing ones, and selects through a mask which flags may drive the single interrupt line.

Edges are found by comparing each status bit with a copy registered on the previous clock. That copy resets to the reset value the status bit is expected to have, so leaving reset creates no event. A new event that lands in the same cycle as a software clear wins, and its flag stays set.

Top module: `serstat_irq`

## Requirements
- R1: Flag bit 0 (transmit complete) sets on the clock edge that first samples `tx_idle_i` high after it was low.
- R2: Flag bit 1 (transmit space) sets on the clock edge that first samples `tx_free_i` high after it was low.
- R3: Flag bit 2 (receive data) sets on the clock edge that first samples `rx_valid_i` high after it was low.
- R4: Flag bits 3 and 4 (transmit DMA buffer A and B done) and bits 5 and 6 (receive DMA buffer A and B done) set when `txdma_act_i[0]`, `txdma_act_i[1]`, `rxdma_act_i[0]` and `rxdma_act_i[1]` respectively go from 1 to 0. A change in the opposite direction sets nothing.
- R5: Flag bit 7 (receive overrun) and flag bit 8 (transmit underrun) set on any clock edge that samples `rx_ovr_i` or `tx_und_i` high, respectively.
- R6: After reset the flags, the mask and `irq_o` are all 0. Status inputs held at their reset values (`tx_idle_i`=1, `tx_free_i`=1, all other status bits 0) then raise no flag.
- R7: A set flag stays set until it is cleared, whatever its status input does.
- R8: A write with `clr_we_i` high clears every flag whose bit in `clr_data_i` is 1. Flags whose bit is 0 keep their value.
- R9: When an event and a clear of the same flag fall in the same cycle, the flag is 1 after that edge.
- R10: A write with `mask_we_i` high loads `mask_data_i` into `mask_o` on the next edge. The mask never changes any flag.
- R11: `irq_o` is a register. After every edge it equals the OR over all bits of `flags_o & mask_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_idle_i | input | 1 | Transmit FIFO empty and shifter idle |
| tx_free_i | input | 1 | Transmit FIFO has room |
| rx_valid_i | input | 1 | Receive FIFO holds data |
| txdma_act_i | input | 2 | Transmit DMA buffer A/B active |
| rxdma_act_i | input | 2 | Receive DMA buffer A/B active |
| rx_ovr_i | input | 1 | Pulse: receive byte lost |
| tx_und_i | input | 1 | Pulse: transmit underrun |
| clr_we_i | input | 1 | Write-1-to-clear strobe for the flags |
| clr_data_i | input | 9 | Flag bits to clear |
| mask_we_i | input | 1 | Mask write strobe |
| mask_data_i | input | 9 | New mask value |
| flags_o | output | 9 | Sticky event flags |
| mask_o | output | 9 | Current mask |
| irq_o | output | 1 | Combined, registered interrupt |

## Verification
The bench builds the block with its default parameters: seven status inputs with the transmit-idle and transmit-free bits resetting high, and a mask that resets to zero. Nine flags are small enough that directed passes can drive each status bit through both edge directions one at a time. A long pseudo-random run then mixes simultaneous edges, pulses, partial clears and mask writes, and compares the result every cycle against an arithmetic model. That run reaches event-and-clear collisions on every flag and every mask pattern that matters for the interrupt OR.

// File: rtl/sis_pkg.sv
package sis_pkg;
    // event counts
    localparam int NUM_LVL = 7;
    localparam int NUM_PLS = 2;
    localparam int NUM_EVT = NUM_LVL + NUM_PLS;

    // flag positions
    localparam int EV_TX_DONE  = 0;
    localparam int EV_TX_SPACE = 1;
    localparam int EV_RX_DATA  = 2;
    localparam int EV_TXDMA_A  = 3;
    localparam int EV_TXDMA_B  = 4;
    localparam int EV_RXDMA_A  = 5;
    localparam int EV_RXDMA_B  = 6;
    localparam int EV_RX_OVR   = 7;
    localparam int EV_TX_UND   = 8;

    // 1 = event on falling status bit, 0 = rising
    localparam logic [NUM_LVL-1:0] LVL_FALL = 7'b1111000;

    typedef logic [NUM_EVT-1:0] evt_vec_t;
endpackage

// File: rtl/sis_edge_det.sv
module sis_edge_det #(
    parameter int            N    = 7,
    parameter logic [N-1:0]  FALL = '0,
    parameter logic [N-1:0]  RST  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] evt_o
);
    typedef struct packed {
        logic [N-1:0] prev;
        logic         armed;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.prev  = lvl_i;
        st_d.armed = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev  <= RST;
            st_q.armed <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_bit
        if (FALL[g]) begin : g_fall
            assign evt_o[g] = st_q.prev[g] & ~lvl_i[g];
        end else begin : g_rise
            assign evt_o[g] = ~st_q.prev[g] & lvl_i[g];
        end

        // an unchanged status bit never produces an event (r1..r3 rising, r4 falling)
        p_stable_no_evt_r4: assert property (@(posedge clk) disable iff (!rst_n || !st_q.armed)
            $stable(lvl_i[g]) |-> !evt_o[g]);
    end
endmodule

// File: rtl/sis_flag_bank.sv
module sis_flag_bank #(
    parameter int           N        = 9,
    parameter logic [N-1:0] MASK_RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic         clr_we_i,
    input  logic [N-1:0] clr_i,
    input  logic         mask_we_i,
    input  logic [N-1:0] mask_i,
    output logic [N-1:0] flags_o,
    output logic [N-1:0] mask_o,
    output logic [N-1:0] flags_d_o,
    output logic [N-1:0] mask_d_o
);
    typedef struct packed {
        logic [N-1:0] flags;
        logic [N-1:0] mask;
    } state_t;

    state_t       st_d, st_q;
    logic [N-1:0] clr_eff;

    always_comb begin
        clr_eff  = clr_we_i ? clr_i : '0;
        st_d     = st_q;
        st_d.flags = (st_q.flags & ~clr_eff) | evt_i;
        if (mask_we_i) begin
            st_d.mask = mask_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.flags <= '0;
            st_q.mask  <= MASK_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o   = st_q.flags;
    assign mask_o    = st_q.mask;
    assign flags_d_o = st_d.flags;
    assign mask_d_o  = st_d.mask;

    for (genvar g = 0; g < N; g++) begin : g_chk
        p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_o[g] && !(clr_we_i && clr_i[g])) |=> flags_o[g]);
        p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we_i && clr_i[g] && !evt_i[g]) |=> !flags_o[g]);
        p_evt_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[g] |=> flags_o[g]);
        p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!flags_o[g] && !evt_i[g]) |=> !flags_o[g]);
    end

    p_mask_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we_i |=> (mask_o == $past(mask_i)));
    p_mask_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we_i |=> $stable(mask_o));
endmodule

// File: rtl/sis_irq_merge.sv
module sis_irq_merge #(
    parameter int N = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] flags_d_i,
    input  logic [N-1:0] mask_d_i,
    output logic         irq_o
);
    typedef struct packed {
        logic irq;
    } state_t;

    state_t       st_d, st_q;
    logic [N-1:0] live;

    always_comb begin
        live     = flags_d_i & mask_d_i;
        st_d     = st_q;
        st_d.irq = |live;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.irq <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = st_q.irq;
endmodule

// File: rtl/serstat_irq.sv
module serstat_irq
    import sis_pkg::*;
#(
    parameter logic [NUM_LVL-1:0] LVL_RST  = 7'b0000011,
    parameter logic [NUM_EVT-1:0] MASK_RST = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_idle_i,
    input  logic               tx_free_i,
    input  logic               rx_valid_i,
    input  logic [1:0]         txdma_act_i,
    input  logic [1:0]         rxdma_act_i,
    input  logic               rx_ovr_i,
    input  logic               tx_und_i,
    input  logic               clr_we_i,
    input  logic [NUM_EVT-1:0] clr_data_i,
    input  logic               mask_we_i,
    input  logic [NUM_EVT-1:0] mask_data_i,
    output logic [NUM_EVT-1:0] flags_o,
    output logic [NUM_EVT-1:0] mask_o,
    output logic               irq_o
);
    logic [NUM_LVL-1:0] lvl;
    logic [NUM_LVL-1:0] lvl_evt;
    evt_vec_t           evt;
    evt_vec_t           flags_d;
    evt_vec_t           mask_d;

    always_comb begin
        lvl                          = '0;
        lvl[EV_TX_DONE]              = tx_idle_i;
        lvl[EV_TX_SPACE]             = tx_free_i;
        lvl[EV_RX_DATA]              = rx_valid_i;
        lvl[EV_TXDMA_A]              = txdma_act_i[0];
        lvl[EV_TXDMA_B]              = txdma_act_i[1];
        lvl[EV_RXDMA_A]              = rxdma_act_i[0];
        lvl[EV_RXDMA_B]              = rxdma_act_i[1];
        evt                          = '0;
        evt[NUM_LVL-1:0]             = lvl_evt;
        evt[EV_RX_OVR]               = rx_ovr_i;
        evt[EV_TX_UND]               = tx_und_i;
    end

    sis_edge_det #(
        .N    (NUM_LVL),
        .FALL (LVL_FALL),
        .RST  (LVL_RST)
    ) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i (lvl),
        .evt_o (lvl_evt)
    );

    sis_flag_bank #(
        .N        (NUM_EVT),
        .MASK_RST (MASK_RST)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt),
        .clr_we_i  (clr_we_i),
        .clr_i     (clr_data_i),
        .mask_we_i (mask_we_i),
        .mask_i    (mask_data_i),
        .flags_o   (flags_o),
        .mask_o    (mask_o),
        .flags_d_o (flags_d),
        .mask_d_o  (mask_d)
    );

    sis_irq_merge #(
        .N (NUM_EVT)
    ) u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .flags_d_i (flags_d),
        .mask_d_i  (mask_d),
        .irq_o     (irq_o)
    );

    p_irq_match_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == |(flags_o & mask_o)));
    p_ovr_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovr_i |=> flags_o[EV_RX_OVR]);
    p_und_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_und_i |=> flags_o[EV_TX_UND]);
    p_txdone_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_idle_i) |=> flags_o[EV_TX_DONE]);
    p_txspace_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_free_i) |=> flags_o[EV_TX_SPACE]);
    p_rxdata_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_valid_i) |=> flags_o[EV_RX_DATA]);
endmodule

// File: tb/serstat_irq_bench.sv
module serstat_irq_bench;
    localparam time CYC = 5ns;
    localparam logic [6:0] FALLV  = 7'b1111000;
    localparam logic [6:0] RSTLVL = 7'b0000011;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] lvl = RSTLVL;
    logic [1:0] pls = '0;
    logic       clr_we = 1'b0;
    logic [8:0] clr_d = '0;
    logic       mask_we = 1'b0;
    logic [8:0] mask_d = '0;
    logic [8:0] flags;
    logic [8:0] mask;
    logic       irq;

    int n_tests = 0;
    int n_fail  = 0;

    logic [6:0] m_prev  = RSTLVL;
    logic [8:0] m_flags = '0;
    logic [8:0] m_mask  = '0;

    always #(CYC/2) clk = ~clk;

    serstat_irq u_serstat_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_idle_i   (lvl[0]),
        .tx_free_i   (lvl[1]),
        .rx_valid_i  (lvl[2]),
        .txdma_act_i (lvl[4:3]),
        .rxdma_act_i (lvl[6:5]),
        .rx_ovr_i    (pls[0]),
        .tx_und_i    (pls[1]),
        .clr_we_i    (clr_we),
        .clr_data_i  (clr_d),
        .mask_we_i   (mask_we),
        .mask_data_i (mask_d),
        .flags_o     (flags),
        .mask_o      (mask),
        .irq_o       (irq)
    );

    function automatic string req_of(input int b);
        if (b == 0) return "R1";
        if (b == 1) return "R2";
        if (b == 2) return "R3";
        if (b <= 6) return "R4";
        return "R5";
    endfunction

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic chk_all();
        for (int b = 0; b < 9; b++) chk(req_of(b), {8'b0, flags[b]}, {8'b0, m_flags[b]});
        chk("R10", mask, m_mask);
        chk("R11", {8'b0, irq}, {8'b0, |(m_flags & m_mask)});
    endtask

    // drive one cycle at the negedge, update the model, check after the edge
    task automatic cycle(input logic [6:0] l, input logic [1:0] p, input logic cwe,
                         input logic [8:0] c, input logic mwe, input logic [8:0] m);
        logic [6:0] e_l;
        lvl = l; pls = p; clr_we = cwe; clr_d = c; mask_we = mwe; mask_d = m;
        e_l = (l & ~m_prev & ~FALLV) | (~l & m_prev & FALLV);
        m_flags = (m_flags & ~(cwe ? c : 9'b0)) | {p, e_l};
        if (mwe) m_mask = m;
        m_prev = l;
        @(posedge clk);
        @(negedge clk);
        chk_all();
    endtask

    initial begin
        #(CYC * 150000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] lf;
        logic [6:0]  cur;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R6: reset state
        chk("R6", flags, 9'b0);
        chk("R6", mask, 9'b0);
        chk("R6", {8'b0, irq}, 9'b0);
        cycle(RSTLVL, 2'b00, 1'b0, 9'b0, 1'b0, 9'b0);
        chk("R6", flags, 9'b0);
        // enable all flags onto irq
        cycle(RSTLVL, 2'b00, 1'b0, 9'b0, 1'b1, 9'h1FF);
        // each status bit: wrong direction first, then the firing one
        cur = RSTLVL;
        for (int b = 0; b < 7; b++) begin
            cur[b] = FALLV[b];
            cycle(cur, 2'b00, 1'b0, 9'b0, 1'b0, 9'h1FF);
            chk(req_of(b), flags, 9'b0);
            cur[b] = ~FALLV[b];
            cycle(cur, 2'b00, 1'b0, 9'b0, 1'b0, 9'h1FF);
            chk(req_of(b), flags, 9'(1 << b));
            // R7: return to the idle level, flag stays
            cur[b] = FALLV[b];
            cycle(cur, 2'b00, 1'b0, 9'b0, 1'b0, 9'h1FF);
            chk("R7", flags, 9'(1 << b));
            // R8: clear this bit only
            cycle(cur, 2'b00, 1'b1, 9'(1 << b), 1'b0, 9'h1FF);
            chk("R8", flags, 9'b0);
        end
        for (int b = 7; b < 9; b++) begin
            cycle(cur, 2'(1 << (b - 7)), 1'b0, 9'b0, 1'b0, 9'h1FF);
            chk("R5", flags, 9'(1 << b));
            cycle(cur, 2'b00, 1'b1, 9'h1FF, 1'b0, 9'h1FF);
        end
        // R9: event and clear together
        cycle(cur, 2'b01, 1'b1, 9'h1FF, 1'b0, 9'h1FF);
        chk("R9", {8'b0, flags[7]}, 9'b1);
        cycle(cur, 2'b00, 1'b1, 9'h1FF, 1'b0, 9'h1FF);
        cur[0] = 1'b1;
        cycle(cur, 2'b00, 1'b1, 9'h001, 1'b0, 9'h1FF);
        chk("R9", {8'b0, flags[0]}, 9'b1);
        // R10: mask does not touch flags; R11 follows mask
        cycle(cur, 2'b00, 1'b0, 9'b0, 1'b1, 9'h000);
        chk("R10", flags, 9'h001);
        chk("R11", {8'b0, irq}, 9'b0);
        // R8: clear with strobe low has no effect
        cycle(cur, 2'b00, 1'b0, 9'h1FF, 1'b0, 9'h0);
        chk("R8", flags, 9'h001);
        // pseudo-random mix
        lf = 32'hACE1_2357;
        for (int i = 0; i < 4000; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            cycle(lf[6:0] ^ lf[22:16], lf[8:7] & lf[24:23], lf[9] & lf[10],
                  lf[19:11], lf[25] & lf[26] & lf[27], lf[31:23]);
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule